// File: doc/BRIEF.md
# Cascadable Timer Pair

This block holds two 16-bit up-counters, called the even and the odd timer, each with its own control word, count register and period register. Each timer counts either internal clock cycles or rising edges of its own input pin. The pin is always brought into the internal clock domain first. Counting can be gated by the pin level, and a prescaler with eight ratios divides the chosen source. When a count equals its period on a counting step, the count returns to zero and the timer's event flag is set.

One bit in the even timer's control word fuses the two timers into a single 32-bit counter. The even timer's registers form the low half-word and the odd timer's registers form the high half-word. The even control word alone drives the pair. A match of the whole 32-bit value is reported on the odd timer's flag.

A match on the odd timer, or on the fused pair, also emits a one-cycle pulse that starts an analog-to-digital conversion. Software loads the registers through a simple write port and clears the flags with a per-timer strobe.

Top module: `tmr_duo`

## Requirements
- R1: After reset, both counts are zero, both flags are low and the converter pulse is low.
- R2: Control bits 6:4 pick the prescale ratio: code 0..6 give 1, 2, 4, 8, 16, 32 and 64, and code 7 gives 256. With period P, matches come every (P+1) times the ratio source ticks.
- R3: In 16-bit mode, each timer advances on its own prescaled tick. A tick that finds the count equal to the period loads zero into the count and sets that timer's flag (`flag_even` for the even timer, `flag_odd` for the odd timer).
- R4: `adc_trig` is high for exactly the cycle after a match of the odd timer (16-bit mode) or of the pair (32-bit mode). The flag rises at the same edge, and holding `flag_clr` does not suppress or move the pulse.
- R5: Setting bit 3 of the even control word selects 32-bit mode. In that mode `{count_odd, count_even}` counts as one value, and an all-ones low half carries into the high half at the same edge.
- R6: In 32-bit mode, the match needs both halves equal to their periods. The match sets `flag_odd` and leaves `flag_even` alone. A period of all ones is matched correctly.
- R7: In 32-bit mode, the odd control word's enable, gate, prescale and source fields have no effect on counting.
- R8: With control bit 1 set, the timer counts rising edges of its pin, passed through a two-stage synchroniser.
- R9: With control bit 7 set and bit 1 clear, the timer counts internal cycles only while the synchronised pin is high.
- R10: Control bit 15 enables counting. While it is clear, the count holds its value.
- R11: `flag_clr[i]` clears flag i at the next edge. A flag set in the same cycle takes precedence.
- R12: A write with `wr_reg` 0 loads the control word, 1 loads the count and 2 loads the period of the timer chosen by `wr_tmr` (0 even, 1 odd). A count write takes precedence over a counting step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_even | input | 1 | External clock or gate pin for the even timer |
| pin_odd | input | 1 | External clock or gate pin for the odd timer |
| wr_en | input | 1 | Register write strobe |
| wr_tmr | input | 1 | Target timer of the write (0 even, 1 odd) |
| wr_reg | input | 2 | Target register (0 control, 1 count, 2 period) |
| wr_data | input | HALF_W | Write data |
| flag_clr | input | 2 | Per-timer flag clear strobes (bit 0 even, bit 1 odd) |
| count_even | output | HALF_W | Even timer count (low half in 32-bit mode) |
| count_odd | output | HALF_W | Odd timer count (high half in 32-bit mode) |
| flag_even | output | 1 | Even timer event flag |
| flag_odd | output | 1 | Odd timer or pair event flag |
| adc_trig | output | 1 | One-cycle converter start pulse |

## Verification
The properties assume that a count only jumps to an arbitrary value through a count write. Outside a write cycle, a count either holds, steps by one or returns to zero. The stimulus therefore loads counts and periods only while a timer is stopped, with one deliberate count write to a running timer. The properties also take it that the mode bit is stable whenever it is used to judge the even flag. The bench changes the mode only by writing the even control word between runs. Pin pulses are held for several clocks so that the synchroniser sees every edge.

// File: rtl/tmr_duo_pkg.sv
package tmr_duo_pkg;

   localparam int CTL_W   = 16;
   localparam int B_ON    = 15;
   localparam int B_GATE  = 7;
   localparam int B_PS_LO = 4;
   localparam int PS_W    = 3;
   localparam int B_PAIR  = 3;
   localparam int B_SRC   = 1;
   localparam int PRE_W   = 8;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_PER  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic            on;
      logic            gate;
      logic [PS_W-1:0] ps;
      logic            src;
   } ctl_t;

   function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
      ctl_t c;
      c.on   = w[B_ON];
      c.gate = w[B_GATE];
      c.ps   = w[B_PS_LO +: PS_W];
      c.src  = w[B_SRC];
      return c;
   endfunction

   // terminal value of the prescale counter (ratio minus one)
   function automatic logic [PRE_W-1:0] ps_limit(input logic [PS_W-1:0] code);
      logic [PRE_W:0] r;
      r = (code == 3'd7) ? (PRE_W+1)'(256) : ((PRE_W+1)'(1) << code);
      return PRE_W'(r - (PRE_W+1)'(1));
   endfunction

endpackage

// File: rtl/tmr_duo_sync.sv
module tmr_duo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_duo_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/tmr_duo_tick.sv
module tmr_duo_tick
   import tmr_duo_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            restart,
   input  logic            use_pin,
   input  logic            gate,
   input  logic [PS_W-1:0] ps_code,
   input  logic            pin,
   output logic            tick
);
   logic             pin_s;
   logic             pin_prev_q;
   logic             raw;
   logic             hit;
   logic [PRE_W-1:0] pre_q;

   tmr_duo_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pin_prev_q <= 1'b0;
      else        pin_prev_q <= pin_s;
   end

   always_comb begin
      if (use_pin)   raw = pin_s & ~pin_prev_q;
      else if (gate) raw = pin_s;
      else           raw = 1'b1;
   end

   assign hit  = en & raw & (pre_q == ps_limit(ps_code));
   assign tick = hit & ~restart;

   always_ff @(posedge clk) begin
      if (!rst_n)              pre_q <= '0;
      else if (!en || restart) pre_q <= '0;
      else if (raw)            pre_q <= hit ? '0 : pre_q + 1'b1;
   end
endmodule

// File: rtl/tmr_duo.sv
module tmr_duo
   import tmr_duo_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_even,
   input  logic              pin_odd,
   input  logic              wr_en,
   input  logic              wr_tmr,
   input  logic [1:0]        wr_reg,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [1:0]        flag_clr,
   output logic [HALF_W-1:0] count_even,
   output logic [HALF_W-1:0] count_odd,
   output logic              flag_even,
   output logic              flag_odd,
   output logic              adc_trig
);
   localparam int NT = 2;

   generate
      if (HALF_W < CTL_W) begin : g_bad_width
         $error("tmr_duo: HALF_W must hold a full control word");
      end
   endgenerate

   ctl_t                         ctl_q [NT];
   logic                         pair_mode;
   logic [NT-1:0][HALF_W-1:0]    cnt_q, cnt_d, per_q;
   logic [NT-1:0]                flag_q, flag_d, set_d;
   logic [NT-1:0]                tick, match, wr_cnt, wr_ctl, wr_per;
   logic [NT-1:0]                pins;
   logic                         trig_q, trig_d;

   assign pins = {pin_odd, pin_even};

   always_comb begin
      for (int i = 0; i < NT; i++) begin
         wr_ctl[i] = wr_en && (wr_tmr == 1'(i)) && (wr_reg == SEL_CTL);
         wr_cnt[i] = wr_en && (wr_tmr == 1'(i)) && (wr_reg == SEL_CNT);
         wr_per[i] = wr_en && (wr_tmr == 1'(i)) && (wr_reg == SEL_PER);
         match[i]  = (cnt_q[i] == per_q[i]);
      end
   end

   // per-timer tick sources; the odd unit sleeps while the pair is fused
   for (genvar g = 0; g < NT; g++) begin : g_unit
      logic en_g;
      if (g == 0) begin : g_lead
         assign en_g = ctl_q[g].on;
      end else begin : g_follow
         assign en_g = ctl_q[g].on & ~pair_mode;
      end
      tmr_duo_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (en_g),
         .restart (wr_ctl[g]),
         .use_pin (ctl_q[g].src),
         .gate    (ctl_q[g].gate),
         .ps_code (ctl_q[g].ps),
         .pin     (pins[g]),
         .tick    (tick[g])
      );
   end

   always_comb begin
      cnt_d  = cnt_q;
      set_d  = '0;
      trig_d = 1'b0;
      if (pair_mode) begin
         if (!(|wr_cnt) && tick[0]) begin
            if (match[0] && match[1]) begin
               cnt_d  = '0;
               set_d[1] = 1'b1;
               trig_d = 1'b1;
            end else begin
               cnt_d[0] = cnt_q[0] + 1'b1;
               if (&cnt_q[0]) cnt_d[1] = cnt_q[1] + 1'b1;
            end
         end
      end else begin
         for (int i = 0; i < NT; i++) begin
            if (!wr_cnt[i] && tick[i]) begin
               if (match[i]) begin
                  cnt_d[i] = '0;
                  set_d[i] = 1'b1;
               end else begin
                  cnt_d[i] = cnt_q[i] + 1'b1;
               end
            end
         end
         trig_d = set_d[1];
      end
      for (int i = 0; i < NT; i++) begin
         if (wr_cnt[i]) cnt_d[i] = wr_data;
         flag_d[i] = (flag_q[i] & ~flag_clr[i]) | set_d[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         per_q     <= '0;
         flag_q    <= '0;
         trig_q    <= 1'b0;
         pair_mode <= 1'b0;
         for (int i = 0; i < NT; i++) ctl_q[i] <= '0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
         trig_q <= trig_d;
         for (int i = 0; i < NT; i++) begin
            if (wr_ctl[i]) ctl_q[i] <= ctl_decode(wr_data[CTL_W-1:0]);
            if (wr_per[i]) per_q[i] <= wr_data;
         end
         if (wr_ctl[0]) pair_mode <= wr_data[B_PAIR];
      end
   end

   assign count_even = cnt_q[0];
   assign count_odd  = cnt_q[1];
   assign flag_even  = flag_q[0];
   assign flag_odd   = flag_q[1];
   assign adc_trig   = trig_q;
endmodule

// File: rtl/tmr_duo_chk.sv
module tmr_duo_chk #(
   parameter int HALF_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              pair_mode,
   input logic [HALF_W-1:0] count_even,
   input logic [HALF_W-1:0] count_odd,
   input logic              flag_even,
   input logic              flag_odd,
   input logic              adc_trig
);
   // converter pulse always comes with the odd flag raised
   assert_trig_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> flag_odd);

   // a match returns the odd count to zero unless software wrote it
   assert_trig_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig && !$past(wr_en) |-> count_odd == '0);

   // fused mode never raises the even flag
   assert_even_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pair_mode && $past(pair_mode) |-> !$rose(flag_even));

   // without a write, each half holds, steps by one or clears
   assert_step_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (count_even == $past(count_even)) ||
                        (count_even == $past(count_even) + 1'b1) ||
                        (count_even == '0));

   assert_step_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> (count_odd == $past(count_odd)) ||
                        (count_odd == $past(count_odd) + 1'b1) ||
                        (count_odd == '0));

   // in fused mode a trigger clears both halves
   assert_pair_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig && pair_mode && !$past(wr_en) |-> count_even == '0);
endmodule

bind tmr_duo tmr_duo_chk #(.HALF_W(HALF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .pair_mode  (pair_mode),
   .count_even (count_even),
   .count_odd  (count_odd),
   .flag_even  (flag_even),
   .flag_odd   (flag_odd),
   .adc_trig   (adc_trig)
);

// File: tb/sim_tmr_duo.sv
module sim_tmr_duo;
   localparam logic [15:0] C_ON   = 16'h8000;
   localparam logic [15:0] C_GATE = 16'h0080;
   localparam logic [15:0] C_PAIR = 16'h0008;
   localparam logic [15:0] C_EXT  = 16'h0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_even = 1'b0, pin_odd = 1'b0;
   logic        wr_en = 1'b0, wr_tmr = 1'b0;
   logic [1:0]  wr_reg = 2'd3;
   logic [15:0] wr_data = '0;
   logic [1:0]  flag_clr = '0;
   logic [15:0] count_even, count_odd;
   logic        flag_even, flag_odd, adc_trig;

   int total = 0, bad = 0, cyc = 0, last_e = 0;
   int exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tmr_duo u0 (
      .clk(clk), .rst_n(rst_n), .pin_even(pin_even), .pin_odd(pin_odd),
      .wr_en(wr_en), .wr_tmr(wr_tmr), .wr_reg(wr_reg), .wr_data(wr_data),
      .flag_clr(flag_clr), .count_even(count_even), .count_odd(count_odd),
      .flag_even(flag_even), .flag_odd(flag_odd), .adc_trig(adc_trig)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic t, input logic [1:0] r, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_tmr = t; wr_reg = r; wr_data = d;
      @(negedge clk);
      last_e = cyc;
      wr_en = 1'b0; wr_reg = 2'd3;
   endtask

   task automatic clr(input logic [1:0] m);
      @(negedge clk); flag_clr = m;
      @(negedge clk); flag_clr = '0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // driver side of the scoreboard: expected trigger cycles
   task automatic expect_trigs(input int e, input int p, input int r, input int n);
      for (int m = 1; m <= n; m++) exp_q.push_back(e + m * (p + 1) * r);
   endtask

   task automatic drain;
      int guard = 0;
      while (exp_q.size() != 0 && guard < 3000) begin
         @(negedge clk); guard++;
      end
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R4 missing trigger actual=none expected=%0d", exp_q[0]);
         exp_q.delete();
      end
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && adc_trig) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R4 unexpected trigger actual=%0d expected=none", cyc);
         end else begin
            int x;
            x = exp_q.pop_front();
            if (x != cyc) begin
               bad++;
               $display("FAIL R2/R4 trigger cycle actual=%0d expected=%0d", cyc, x);
            end
         end
      end
   end

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count_even", 32'(count_even), 32'h0);
      chk("R1 count_odd", 32'(count_odd), 32'h0);
      chk("R1 flags", {30'h0, flag_odd, flag_even}, 32'h0);
      chk("R1 trig", 32'(adc_trig), 32'h0);

      // R3 R4: odd timer, ratio 1, period 4
      wr(1, 2, 16'd4);
      wr(1, 0, C_ON);
      expect_trigs(last_e, 4, 1, 3);
      drain();
      wr(1, 0, 16'h0000);
      chk("R3 flag_odd set on match", 32'(flag_odd), 32'h1);
      clr(2'b10);
      chk("R11 flag_odd cleared", 32'(flag_odd), 32'h0);

      // R2: prescale 8, 32, 256
      wr(1, 1, 16'd0); wr(1, 2, 16'd2); wr(1, 0, C_ON | 16'h0030);
      expect_trigs(last_e, 2, 8, 2); drain(); wr(1, 0, 16'h0000);
      wr(1, 1, 16'd0); wr(1, 2, 16'd0); wr(1, 0, C_ON | 16'h0050);
      expect_trigs(last_e, 0, 32, 2); drain(); wr(1, 0, 16'h0000);
      wr(1, 1, 16'd0); wr(1, 2, 16'd1); wr(1, 0, C_ON | 16'h0070);
      expect_trigs(last_e, 1, 256, 2); drain(); wr(1, 0, 16'h0000);

      // R4 trigger unaffected by a held flag clear
      wr(1, 1, 16'd0); wr(1, 2, 16'd3);
      flag_clr = 2'b10;
      wr(1, 0, C_ON);
      expect_trigs(last_e, 3, 1, 2); drain();
      wr(1, 0, 16'h0000);
      flag_clr = '0;
      @(negedge clk);
      chk("R11 flag_odd low after held clear", 32'(flag_odd), 32'h0);

      // R3 R10: even timer alone
      wr(0, 1, 16'd0); wr(0, 2, 16'd2); wr(0, 0, C_ON);
      c0 = last_e;
      wait_until(c0 + 2);
      chk("R3 count_even before match", 32'(count_even), 32'd2);
      wait_until(c0 + 3);
      chk("R3 count_even wraps", 32'(count_even), 32'd0);
      chk("R3 flag_even set", 32'(flag_even), 32'h1);
      chk("R3 flag_odd untouched", 32'(flag_odd), 32'h0);
      wr(0, 0, 16'h0000);
      c0 = count_even;
      repeat (10) @(negedge clk);
      chk("R10 count holds when disabled", 32'(count_even), 32'(c0));
      clr(2'b01);

      // R5 R6 R7: fused pair with carry; odd control set to odd values
      wr(0, 1, 16'hFFFE); wr(1, 1, 16'h0000);
      wr(0, 2, 16'h0002); wr(1, 2, 16'h0001);
      wr(1, 0, C_ON | C_GATE | 16'h0070 | C_EXT);
      wr(0, 0, C_ON | C_PAIR);
      c0 = last_e;
      exp_q.push_back(c0 + 5);
      wait_until(c0 + 2);
      chk("R5 carry high half", 32'(count_odd), 32'h1);
      chk("R5 carry low half", 32'(count_even), 32'h0);
      wait_until(c0 + 5);
      chk("R6 pair match clears", {count_odd, count_even}, 32'h0);
      chk("R6 flag_odd set", 32'(flag_odd), 32'h1);
      chk("R6 flag_even stays low", 32'(flag_even), 32'h0);
      drain();
      wr(0, 0, 16'h0000);
      wr(1, 0, 16'h0000);
      clr(2'b11);

      // R6 all-ones period
      wr(0, 1, 16'hFFFD); wr(1, 1, 16'hFFFF);
      wr(0, 2, 16'hFFFF); wr(1, 2, 16'hFFFF);
      wr(0, 0, C_ON | C_PAIR);
      c0 = last_e;
      exp_q.push_back(c0 + 3);
      wait_until(c0 + 2);
      chk("R6 reaches all ones", {count_odd, count_even}, 32'hFFFF_FFFF);
      wait_until(c0 + 3);
      chk("R6 all-ones match clears", {count_odd, count_even}, 32'h0);
      chk("R6 flag_even low all-ones", 32'(flag_even), 32'h0);
      drain();
      wr(0, 0, 16'h0000);
      clr(2'b11);

      // R8 external clock edges
      wr(0, 1, 16'd0); wr(0, 2, 16'd100); wr(0, 0, C_ON | C_EXT);
      for (int k = 0; k < 6; k++) begin
         pin_even = 1'b1; repeat (3) @(negedge clk);
         pin_even = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk("R8 external edges counted", 32'(count_even), 32'd6);
      wr(0, 0, 16'h0000);

      // R9 gated internal clock
      wr(0, 1, 16'd0); wr(0, 0, C_ON | C_GATE);
      repeat (10) @(negedge clk);
      chk("R9 gate low holds", 32'(count_even), 32'd0);
      pin_even = 1'b1;
      repeat (20) @(negedge clk);
      pin_even = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9 gate high counts", 32'(count_even), 32'd20);
      wr(0, 0, 16'h0000);

      // R12 count write beats a counting step
      wr(0, 2, 16'hFFFF); wr(0, 1, 16'd0); wr(0, 0, C_ON);
      repeat (4) @(negedge clk);
      wr(0, 1, 16'h1234);
      c0 = last_e;
      chk("R12 write wins", 32'(count_even), 32'h1234);
      wait_until(c0 + 1);
      chk("R12 counting resumes", 32'(count_even), 32'h1235);
      wr(0, 0, 16'h0000);

      repeat (5) @(negedge clk);
      summary();
   end
endmodule